// File: doc/BRIEF.md
# Serial-Loaded Bank Register File

This block sits on an 8-bit CPU write bus and builds four 5-bit configuration values from single-bit writes. In the upper half of the address space, every accepted write adds data bit 0 to a loader. The loader fills LSB first. On the fifth accepted write, the assembled value goes to one of four registers, and address bits 14:13 of that fifth write select which one. The four registers are the control register, low pattern bank, high pattern bank and program bank. They feed a downstream address translator.

A write in the upper half with data bit 7 set restarts the loader at once and forces the two mode bits of the control register high. Serial writes are limited to one per CPU cycle. After a serial write is accepted, further serial writes are dropped until the per-cycle tick is seen. Writes in a RAM window below the upper half are forwarded combinationally to a RAM write port, with the address rebased to zero. Writes below that window have no effect.

The write interface is a plain strobe with no back-pressure. The block takes every strobe in the cycle it is presented, and nothing is held over.

Top module: `serial_bank_regfile`

## Requirements
- R1: After reset all four registers read 0, the loader is empty and the once-per-cycle flag is clear.
- R2: A write to 0x8000–0xFFFF with data bit 7 clear is a serial write. The data bit 0 of the k-th accepted serial write (k = 0..4) becomes bit k of the committed value. The value is committed on the clock edge of the fifth accepted write, and the loader then starts empty.
- R3: The commit target is chosen by address bits 14:13 of the fifth write: 00 selects control, 01 the low pattern bank, 10 the high pattern bank, and 11 the program bank.
- R4: Before the fifth accepted serial write, no register changes. Without a write strobe, no register changes.
- R5: A write to 0x8000–0xFFFF with data bit 7 set empties the loader and sets control bits 3:2 to 11. Control bits 4, 1 and 0 and the other three registers are unchanged.
- R6: Once a serial write is accepted, later serial writes are ignored until a clock edge with the cycle tick high. A write presented together with the tick is judged against the flag as it stood before that edge, and the flag is clear after the edge.
- R7: A bit-7 restart write is acted on even when the flag is set, and it never sets the flag.
- R8: A write to 0x6000–0x7FFF raises the RAM write enable in the same cycle, with RAM address = address − 0x6000 and the write data passed through unchanged. Such a write leaves the registers and the loader untouched.
- R9: A write below 0x6000 raises no RAM enable and changes no register and no loader state.
- R10: Data bits 6:1 of a serial write have no effect on the committed value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cyc_tick | input | 1 | CPU-cycle boundary; clears the once-per-cycle flag |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 16 | CPU write address |
| wr_data | input | 8 | CPU write data |
| ram_we | output | 1 | RAM write enable (combinational) |
| ram_addr | output | 13 | RAM offset address |
| ram_wdata | output | 8 | RAM write data |
| cfg_ctrl | output | 5 | Control register |
| cfg_chr_lo | output | 5 | Low pattern bank register |
| cfg_chr_hi | output | 5 | High pattern bank register |
| cfg_prg | output | 5 | Program bank register |

## Verification
Two pairs of events can fall on the same clock edge. The first pair is a serial write and the cycle tick. The bench presents a write with the tick high and checks that the write is accepted and that the next write is accepted too. It also presents a write with the tick high while the flag is already set, and checks that this write is dropped, by counting how many writes it then takes to reach a commit. The second pair is a restart write and a flag that is still set. The bench issues a restart after an accepted serial write and before any tick, then confirms that the loader restarted, that control bits 3:2 went high, and that the flag did not block the next cycle's serial write. A behavioural reference model with a bit queue is compared against all four registers on every clock.

// File: rtl/sbr_pkg.sv
`timescale 1ns/1ps
package sbr_pkg;
  typedef enum logic [1:0] {
    TGT_CTRL = 2'd0,
    TGT_CHR0 = 2'd1,
    TGT_CHR1 = 2'd2,
    TGT_PRG  = 2'd3
  } sbr_tgt_e;

  localparam int unsigned NUM_TGT = 4;

  typedef struct packed {
    logic     serial;   // upper-half write, bit 7 clear
    logic     restart;  // upper-half write, bit 7 set
    logic     ram;      // write inside the RAM window
    sbr_tgt_e tgt;      // register selected by the address
  } sbr_dec_t;
endpackage

// File: rtl/sbr_decode.sv
`timescale 1ns/1ps
module sbr_decode
  import sbr_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int DATA_W   = 8,
  parameter int RAM_BASE = 'h6000,
  parameter int RAM_SPAN = 'h2000,
  localparam int RAM_AW  = $clog2(RAM_SPAN)
) (
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic              flag_bit,
  output sbr_dec_t          dec,
  output logic [RAM_AW-1:0] ram_off
);
  localparam logic [RAM_AW-1:0] RAM_OFS = RAM_AW'(RAM_BASE);

  logic upper;
  logic in_ram;

  assign upper  = wr_addr[ADDR_W-1];
  assign in_ram = (int'(wr_addr) >= RAM_BASE) && (int'(wr_addr) < RAM_BASE + RAM_SPAN);

  always_comb begin
    dec         = '0;
    dec.serial  = wr_en && upper && !flag_bit;
    dec.restart = wr_en && upper && flag_bit;
    dec.ram     = wr_en && !upper && in_ram;
    dec.tgt     = sbr_tgt_e'(wr_addr[ADDR_W-2 -: 2]);
  end

  assign ram_off = wr_addr[RAM_AW-1:0] - RAM_OFS;
endmodule

// File: rtl/sbr_loader.sv
`timescale 1ns/1ps
module sbr_loader #(
  parameter int VAL_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take,
  input  logic             restart,
  input  logic             din,
  output logic             commit,
  output logic [VAL_W-1:0] commit_val
);
  localparam logic [VAL_W-1:0] MARK = {1'b1, {(VAL_W-1){1'b0}}};

  logic [VAL_W-1:0] shift_q;
  logic [VAL_W-1:0] shifted;

  assign shifted    = {din, shift_q[VAL_W-1:1]};
  assign commit     = take && shift_q[0];
  assign commit_val = shifted;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shift_q <= MARK;
    end else if (restart) begin
      shift_q <= MARK;
    end else if (take) begin
      shift_q <= shift_q[0] ? MARK : shifted;
    end
  end
endmodule

// File: rtl/sbr_regs.sv
`timescale 1ns/1ps
module sbr_regs
  import sbr_pkg::*;
#(
  parameter int VAL_W    = 5,
  parameter int MODE_LSB = 2,
  parameter int MODE_W   = 2
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            commit,
  input  sbr_tgt_e                        tgt,
  input  logic [VAL_W-1:0]                val,
  input  logic                            restart,
  output logic [NUM_TGT-1:0][VAL_W-1:0]   regs_q
);
  localparam logic [VAL_W-1:0] MODE_MASK = VAL_W'(((1 << MODE_W) - 1) << MODE_LSB);

  for (genvar g = 0; g < NUM_TGT; g++) begin : g_reg
    logic hit;
    assign hit = commit && (tgt == sbr_tgt_e'(g));
    if (g == int'(TGT_CTRL)) begin : g_ctrl
      always_ff @(posedge clk) begin
        if (!rst_n)       regs_q[g] <= '0;
        else if (hit)     regs_q[g] <= val;
        else if (restart) regs_q[g] <= regs_q[g] | MODE_MASK;
      end
    end else begin : g_bank
      always_ff @(posedge clk) begin
        if (!rst_n)   regs_q[g] <= '0;
        else if (hit) regs_q[g] <= val;
      end
    end
  end
endmodule

// File: rtl/serial_bank_regfile.sv
`timescale 1ns/1ps
module serial_bank_regfile
  import sbr_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int DATA_W   = 8,
  parameter int VAL_W    = 5,
  parameter int RAM_BASE = 'h6000,
  parameter int RAM_SPAN = 'h2000,
  parameter int MODE_LSB = 2,
  parameter int MODE_W   = 2,
  localparam int RAM_AW  = $clog2(RAM_SPAN)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cyc_tick,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              ram_we,
  output logic [RAM_AW-1:0] ram_addr,
  output logic [DATA_W-1:0] ram_wdata,
  output logic [VAL_W-1:0]  cfg_ctrl,
  output logic [VAL_W-1:0]  cfg_chr_lo,
  output logic [VAL_W-1:0]  cfg_chr_hi,
  output logic [VAL_W-1:0]  cfg_prg
);
  sbr_dec_t                      dec;
  logic                          wr_flag_q;
  logic                          take;
  logic                          commit;
  logic [VAL_W-1:0]              commit_val;
  logic [NUM_TGT-1:0][VAL_W-1:0] regs_q;

  sbr_decode #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .RAM_BASE(RAM_BASE), .RAM_SPAN(RAM_SPAN)
  ) u_dec (
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .flag_bit(wr_data[DATA_W-1]),
    .dec     (dec),
    .ram_off (ram_addr)
  );

  // one serial write per CPU cycle; restart writes are not gated
  assign take = dec.serial && !wr_flag_q;

  always_ff @(posedge clk) begin
    if (!rst_n)        wr_flag_q <= 1'b0;
    else if (cyc_tick) wr_flag_q <= 1'b0;
    else if (take)     wr_flag_q <= 1'b1;
  end

  sbr_loader #(.VAL_W(VAL_W)) u_load (
    .clk       (clk),
    .rst_n     (rst_n),
    .take      (take),
    .restart   (dec.restart),
    .din       (wr_data[0]),
    .commit    (commit),
    .commit_val(commit_val)
  );

  sbr_regs #(.VAL_W(VAL_W), .MODE_LSB(MODE_LSB), .MODE_W(MODE_W)) u_regs (
    .clk    (clk),
    .rst_n  (rst_n),
    .commit (commit),
    .tgt    (dec.tgt),
    .val    (commit_val),
    .restart(dec.restart),
    .regs_q (regs_q)
  );

  assign ram_we     = dec.ram;
  assign ram_wdata  = wr_data;
  assign cfg_ctrl   = regs_q[TGT_CTRL];
  assign cfg_chr_lo = regs_q[TGT_CHR0];
  assign cfg_chr_hi = regs_q[TGT_CHR1];
  assign cfg_prg    = regs_q[TGT_PRG];
endmodule

// File: rtl/sbr_checker.sv
`timescale 1ns/1ps
module sbr_checker #(
  parameter int ADDR_W   = 16,
  parameter int DATA_W   = 8,
  parameter int VAL_W    = 5,
  parameter int MODE_LSB = 2,
  parameter int MODE_W   = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cyc_tick,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [DATA_W-1:0] wr_data,
  input logic              ram_we,
  input logic [DATA_W-1:0] ram_wdata,
  input logic [VAL_W-1:0]  cfg_ctrl,
  input logic [VAL_W-1:0]  cfg_chr_lo,
  input logic [VAL_W-1:0]  cfg_chr_hi,
  input logic [VAL_W-1:0]  cfg_prg,
  input logic              wr_flag
);
  localparam logic [VAL_W-1:0] MODE_MASK = VAL_W'(((1 << MODE_W) - 1) << MODE_LSB);

  logic up_wr, rst_wr, ser_wr;
  assign up_wr  = wr_en && wr_addr[ADDR_W-1];
  assign rst_wr = up_wr && wr_data[DATA_W-1];
  assign ser_wr = up_wr && !wr_data[DATA_W-1];

  p_idle_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(cfg_ctrl) && $stable(cfg_chr_lo) && $stable(cfg_chr_hi) && $stable(cfg_prg));

  p_restart_mode_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rst_wr |=> (cfg_ctrl & MODE_MASK) == MODE_MASK);

  p_restart_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rst_wr |=> ((cfg_ctrl & ~MODE_MASK) == ($past(cfg_ctrl) & ~MODE_MASK))
               && $stable(cfg_chr_lo) && $stable(cfg_chr_hi) && $stable(cfg_prg));

  p_dup_ignored_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_wr && wr_flag) |=> $stable(cfg_ctrl) && $stable(cfg_chr_lo)
                            && $stable(cfg_chr_hi) && $stable(cfg_prg));

  p_tick_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_tick |=> !wr_flag);

  p_restart_noflag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_wr && !wr_flag) |=> !wr_flag);

  p_ram_fwd_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |-> wr_en && !wr_addr[ADDR_W-1] && (ram_wdata == wr_data));

  p_low_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_addr[ADDR_W-1]) |=> $stable(cfg_ctrl) && $stable(cfg_chr_lo)
                                     && $stable(cfg_chr_hi) && $stable(cfg_prg));
endmodule

bind serial_bank_regfile sbr_checker #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .VAL_W(VAL_W), .MODE_LSB(MODE_LSB), .MODE_W(MODE_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cyc_tick  (cyc_tick),
  .wr_en     (wr_en),
  .wr_addr   (wr_addr),
  .wr_data   (wr_data),
  .ram_we    (ram_we),
  .ram_wdata (ram_wdata),
  .cfg_ctrl  (cfg_ctrl),
  .cfg_chr_lo(cfg_chr_lo),
  .cfg_chr_hi(cfg_chr_hi),
  .cfg_prg   (cfg_prg),
  .wr_flag   (wr_flag_q)
);

// File: tb/serial_bank_regfile_bench.sv
`timescale 1ns/1ps
module serial_bank_regfile_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cyc_tick = 1'b0;
  logic        wr_en = 1'b0;
  logic [15:0] wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic        ram_we;
  logic [12:0] ram_addr;
  logic [7:0]  ram_wdata;
  logic [4:0]  cfg_ctrl, cfg_chr_lo, cfg_chr_hi, cfg_prg;

  always #5 clk = ~clk;

  serial_bank_regfile u_serial_bank_regfile (
    .clk(clk), .rst_n(rst_n), .cyc_tick(cyc_tick), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .ram_we(ram_we), .ram_addr(ram_addr),
    .ram_wdata(ram_wdata), .cfg_ctrl(cfg_ctrl), .cfg_chr_lo(cfg_chr_lo),
    .cfg_chr_hi(cfg_chr_hi), .cfg_prg(cfg_prg)
  );

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // behavioural reference: a queue of collected bits
  logic [4:0] m_reg [4];
  bit         m_flag;
  bit         m_bits[$];

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 4; i++) m_reg[i] = '0;
      m_flag = 1'b0;
      m_bits.delete();
    end else begin
      if (wr_en && wr_addr[15]) begin
        if (wr_data[7]) begin
          m_bits.delete();
          m_reg[0] = m_reg[0] | 5'h0C;
        end else if (!m_flag) begin
          m_bits.push_back(wr_data[0]);
          m_flag = 1'b1;
          if (m_bits.size() == 5) begin
            logic [4:0] v;
            for (int i = 0; i < 5; i++) v[i] = m_bits[i];
            m_reg[wr_addr[14:13]] = v;
            m_bits.delete();
          end
        end
      end
      if (cyc_tick) m_flag = 1'b0;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R2 R3 model ctrl", int'(cfg_ctrl), int'(m_reg[0]));
      chk("R2 R3 model chr_lo", int'(cfg_chr_lo), int'(m_reg[1]));
      chk("R2 R3 model chr_hi", int'(cfg_chr_hi), int'(m_reg[2]));
      chk("R2 R3 model prg", int'(cfg_prg), int'(m_reg[3]));
    end
  end

  task automatic wr(input logic [15:0] a, input logic [7:0] d, input bit t);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d; cyc_tick = t;
    #1;
    if (a >= 16'h6000 && a < 16'h8000) begin
      chk("R8 ram_we", int'(ram_we), 1);
      chk("R8 ram_addr", int'(ram_addr), int'(a - 16'h6000));
      chk("R8 ram_wdata", int'(ram_wdata), int'(d));
    end else begin
      chk("R9 ram_we", int'(ram_we), 0);
    end
  endtask

  task automatic idle(input int n, input bit t);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      wr_en = 1'b0; cyc_tick = t;
      #1;
    end
  endtask

  task automatic load5(input logic [15:0] a, input logic [4:0] v, input logic [5:0] junk);
    for (int i = 0; i < 5; i++) wr(a, {1'b0, junk, v[i]}, 1'b1);
    idle(1, 1'b0);
  endtask

  task automatic finish_up();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    #2_000_000;
    n_chk++; n_err++;
    $display("FAIL watchdog R1 actual=hung expected=finished");
    finish_up();
  end

  initial begin
    idle(3, 1'b0);
    @(negedge clk); rst_n = 1'b1; #1;
    chk("R1 ctrl", int'(cfg_ctrl), 0);
    chk("R1 chr_lo", int'(cfg_chr_lo), 0);
    chk("R1 chr_hi", int'(cfg_chr_hi), 0);
    chk("R1 prg", int'(cfg_prg), 0);

    // R4, R2, R10: four writes, no commit; fifth commits; junk in bits 6:1
    for (int i = 0; i < 4; i++) wr(16'hA000, {1'b0, 6'h3F, 5'b10110 >> i} & 8'h7F | (((5'b10110 >> i) & 1) ? 8'h00 : 8'h00), 1'b1);
    idle(1, 1'b0);
    chk("R4 no early commit", int'(cfg_chr_lo), 0);
    wr(16'hA000, 8'h7F, 1'b1);
    idle(1, 1'b0);
    chk("R2 R10 chr_lo value", int'(cfg_chr_lo), 'h16);

    // R3: other targets
    load5(16'hE123, 5'h0B, 6'h15);
    chk("R3 prg", int'(cfg_prg), 'h0B);
    load5(16'hC000, 5'h1D, 6'h00);
    chk("R3 chr_hi", int'(cfg_chr_hi), 'h1D);
    load5(16'h8000, 5'h05, 6'h2A);
    chk("R3 ctrl", int'(cfg_ctrl), 'h05);

    // R5: restart mid-sequence
    wr(16'h8000, 8'h01, 1'b1);
    wr(16'h8000, 8'h01, 1'b1);
    wr(16'h9FFF, 8'h80, 1'b1);
    idle(1, 1'b0);
    chk("R5 ctrl mode forced", int'(cfg_ctrl), 'h0D);
    load5(16'h8000, 5'h12, 6'h00);
    chk("R5 reload after restart", int'(cfg_ctrl), 'h12);

    // R6: second write in same cycle (even with tick) dropped
    wr(16'hA000, 8'h01, 1'b0);
    wr(16'hA000, 8'h00, 1'b1);
    wr(16'hA000, 8'h00, 1'b1);
    wr(16'hA000, 8'h01, 1'b1);
    wr(16'hA000, 8'h01, 1'b1);
    idle(1, 1'b0);
    chk("R6 dup not counted", int'(cfg_chr_lo), 'h16);
    wr(16'hA000, 8'h00, 1'b1);
    idle(1, 1'b0);
    chk("R6 value after dup", int'(cfg_chr_lo), 'h0D);

    // R7: restart honoured with flag set, and does not set the flag
    wr(16'hC000, 8'h01, 1'b0);
    wr(16'hC000, 8'h80, 1'b0);
    idle(1, 1'b1);
    idle(1, 1'b0);
    chk("R7 restart while flagged", int'(cfg_ctrl), 'h1E);
    wr(16'hC000, 8'h80, 1'b0);
    load5(16'hC000, 5'h07, 6'h00);
    chk("R7 restart leaves flag clear", int'(cfg_chr_hi), 'h07);

    // R8: RAM window passthrough
    wr(16'h6000, 8'hA5, 1'b1);
    wr(16'h7FFF, 8'h3C, 1'b1);
    wr(16'h6ABC, 8'h01, 1'b1);
    idle(1, 1'b0);
    chk("R8 regs untouched", int'(cfg_chr_hi), 'h07);

    // R9: low writes ignored
    for (int i = 0; i < 5; i++) wr(16'h5FFF - 16'(i), 8'h01, 1'b1);
    wr(16'h0000, 8'h80, 1'b1);
    idle(1, 1'b0);
    chk("R9 prg untouched", int'(cfg_prg), 'h0B);
    chk("R9 ctrl untouched", int'(cfg_ctrl), 'h1E);
    load5(16'hE000, 5'h11, 6'h00);
    chk("R9 loader untouched", int'(cfg_prg), 'h11);

    idle(2, 1'b0);
    finish_up();
  end
endmodule